// File: doc/BRIEF.md
# Polling Receiver Mode Sequencer

This block decides, clock by clock, which mode a duty-cycled radio receiver is in. Left to itself it polls. It sleeps for a programmed time, then runs a start-up phase of fixed length. After that it asks an external bit checker whether a valid signal is present. A passing check moves the receiver into receiving mode. A failing check sends it back to sleep for another programmed period. A bit-check count of zero skips the check and goes straight to receiving.

An active-low override pin lets a host take over. The pin is synchronized first. While the pin is held low, the block ignores the programmed sleep time and bit-check count, goes through start-up and settles in receiving mode. When the pin is released, the block returns to polling after a fixed delay, using the sleep time programmed at that moment. The highest sleep code parks the receiver in sleep until the host pulls the override low. Analog start-up is modelled as a parameterized cycle count.

Top module: `polling_mode_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mode` is sleep (encoding: 0 sleep, 1 start-up, 2 bit check, 3 receiving) and both enables are low.
- R2: A sleep code c below 31 holds `mode` at sleep for exactly (c+1)*SLEEP_UNIT cycles. Then `mode` becomes start-up. The code is sampled when sleep is entered, or during reset.
- R3: A sleep code of 31 keeps `mode` at sleep indefinitely while `force_rx_n` stays high.
- R4: Start-up lasts exactly STARTUP_CYC cycles. With a nonzero `check_count`, bit check follows. `startup_en` is high exactly in start-up, `bitchk_en` is high exactly in bit check, and the two are never high together.
- R5: When `check_count` is zero at the end of start-up, the block moves straight to receiving.
- R6: A `chk_pass` during bit check gives receiving one cycle later. Receiving is then held until the override is released.
- R7: A `chk_fail` without `chk_pass` during bit check gives sleep one cycle later, with a fresh period taken from the sleep code of that cycle.
- R8: When `force_rx_n` falls during sleep, `mode` becomes start-up at the ON_DLY+3rd rising edge after the fall. This happens for every sleep code, including 31.
- R9: While the override is low, the end of start-up leads to receiving whatever `check_count` holds. During bit check, `mode` becomes receiving at the ON_DLY+3rd edge after the fall. Changing the programmed inputs has no effect while the override is low.
- R10: When `force_rx_n` rises during receiving, `mode` becomes sleep at the OFF_DLY+4th rising edge after the rise. The sleep period then follows the sleep code present at that time.
- R11: An override low pulse shorter than ON_DLY clock periods leaves `mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_rx_n | input | 1 | Asynchronous override pin, active low |
| sleep_code | input | 5 | Programmed sleep time; 31 parks in sleep |
| check_count | input | CNT_W | Programmed bit-check count; 0 skips the check |
| chk_pass | input | 1 | Bit checker reports a valid signal |
| chk_fail | input | 1 | Bit checker reports no valid signal |
| mode | output | 2 | Current mode: 0 sleep, 1 start-up, 2 bit check, 3 receiving |
| startup_en | output | 1 | Enable for the start-up timer |
| bitchk_en | output | 1 | Enable for the bit checker |

## Verification
The bench drives inputs on falling edges and samples `mode` on falling edges. It counts rising edges until the expected mode appears:
- bit-check results take effect one edge later;
- an override fall takes effect ON_DLY+3 edges later;
- an override rise takes effect OFF_DLY+4 edges later.

Sleep and start-up are measured as the number of consecutive falling-edge samples spent in that mode. These counts are compared with (c+1)*SLEEP_UNIT and STARTUP_CYC. The enables are checked on the same samples. Random sleep codes, check counts and outcomes are combined with directed runs for parking, a short override glitch, and forced entry from both sleep and bit check.

// File: rtl/rx_seq_pkg.sv
// Package: shared mode encoding for the polling receiver sequencer.
// Assumes: two-bit mode bus seen by neighbouring logic uses these values.
package rx_seq_pkg;

    typedef enum logic [1:0] {
        RXM_SLEEP   = 2'd0,
        RXM_STARTUP = 2'd1,
        RXM_BITCHK  = 2'd2,
        RXM_RECEIVE = 2'd3
    } rx_mode_e;

endpackage

// File: rtl/rx_ovr_filter.sv
// Module: rx_ovr_filter
// Synchronizes the active-low override pin. It raises force_on once the pin
// has been seen low for ON_DLY cycles. It pulses rel_pulse OFF_DLY cycles
// after a synchronized rising edge.
// Assumes: ON_DLY >= 1, OFF_DLY >= 0; the pin is asynchronous to clk.
module rx_ovr_filter #(
    parameter int ON_DLY  = 4,
    parameter int OFF_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic force_on,
    output logic rel_pulse
);
    localparam int ON_W  = $clog2(ON_DLY + 1);
    localparam int OFF_W = $clog2(OFF_DLY + 2);

    logic [2:0]       sync_q;
    logic             synced;
    logic             prev;
    logic             rise;
    logic [ON_W-1:0]  hold_cnt;
    logic [OFF_W-1:0] rel_cnt;
    logic             rel_pend;

    assign synced = sync_q[1];
    assign prev   = sync_q[2];
    assign rise   = synced & ~prev;

    // Two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], pin_n};
    end

    // Count consecutive synchronized-low cycles, saturating at ON_DLY.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_cnt <= '0;
        else if (synced)                      hold_cnt <= '0;
        else if (hold_cnt != ON_W'(ON_DLY))   hold_cnt <= hold_cnt + 1'b1;
    end

    assign force_on = (hold_cnt == ON_W'(ON_DLY));

    // Time the release delay that follows a synchronized rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pend <= 1'b0;
            rel_cnt  <= '0;
        end else if (rise) begin
            rel_pend <= 1'b1;
            rel_cnt  <= '0;
        end else if (!synced) begin
            rel_pend <= 1'b0;
        end else if (rel_pend) begin
            if (rel_pulse) rel_pend <= 1'b0;
            else           rel_cnt  <= rel_cnt + 1'b1;
        end
    end

    assign rel_pulse = rel_pend && (rel_cnt == OFF_W'(OFF_DLY));

endmodule

// File: rtl/rx_down_timer.sv
// Module: rx_down_timer
// A loadable down-counter. done is high while the count is zero and hold is
// low. During reset the counter takes load_val, so that the first period is
// already armed when reset is released.
// Assumes: load_val is stable while reset is applied.
module rx_down_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         hold,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero unless held.
    always_ff @(posedge clk) begin
        if (!rst_n || load)            cnt <= load_val;
        else if (cnt != '0 && !hold)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0) && !hold;

endmodule

// File: rtl/rx_mode_fsm.sv
// Module: rx_mode_fsm
// The four-state mode controller. It produces one-cycle load strobes for the
// sleep and start-up timers on entry to those states.
// Assumes: timer done inputs are only meaningful in their own state.
module rx_mode_fsm
    import rx_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     force_on,
    input  logic     rel_pulse,
    input  logic     sleep_done,
    input  logic     start_done,
    input  logic     chk_bypass,
    input  logic     chk_pass,
    input  logic     chk_fail,
    output rx_mode_e state,
    output logic     load_sleep,
    output logic     load_start
);
    rx_mode_e nxt;

    // Next-state selection; the override has priority over the programmed flow.
    always_comb begin
        nxt = state;
        unique case (state)
            RXM_SLEEP:   if (force_on || sleep_done) nxt = RXM_STARTUP;
            RXM_STARTUP: if (start_done)
                             nxt = (force_on || chk_bypass) ? RXM_RECEIVE : RXM_BITCHK;
            RXM_BITCHK:  if (force_on || chk_pass) nxt = RXM_RECEIVE;
                         else if (chk_fail)        nxt = RXM_SLEEP;
            RXM_RECEIVE: if (rel_pulse) nxt = RXM_SLEEP;
            default:     nxt = RXM_SLEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RXM_SLEEP;
        else        state <= nxt;
    end

    assign load_sleep = (state != RXM_SLEEP)   && (nxt == RXM_SLEEP);
    assign load_start = (state != RXM_STARTUP) && (nxt == RXM_STARTUP);

endmodule

// File: rtl/polling_mode_seq.sv
// Module: polling_mode_seq (top)
// Polling receiver mode sequencer: sleep, start-up, bit check, receiving.
// It has an active-low override and a park code (all-ones sleep code).
// Assumes: chk_pass/chk_fail come from a bit checker that runs while
// bitchk_en is high; sleep_code is stable during reset.
module polling_mode_seq
    import rx_seq_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int CNT_W       = 4,
    parameter int SLEEP_UNIT  = 4,
    parameter int STARTUP_CYC = 6,
    parameter int ON_DLY      = 4,
    parameter int OFF_DLY     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_rx_n,
    input  logic [CODE_W-1:0] sleep_code,
    input  logic [CNT_W-1:0] check_count,
    input  logic             chk_pass,
    input  logic             chk_fail,
    output logic [1:0]       mode,
    output logic             startup_en,
    output logic             bitchk_en
);
    localparam int SLP_W = $clog2((2 ** CODE_W) * SLEEP_UNIT);
    localparam int ST_W  = $clog2(STARTUP_CYC + 1);
    localparam logic [CODE_W-1:0] PARK_CODE = '1;

    rx_mode_e         state;
    logic             force_on;
    logic             rel_pulse;
    logic             sleep_done;
    logic             start_done;
    logic             load_sleep;
    logic             load_start;
    logic             park_q;
    logic             chk_bypass;
    logic [SLP_W-1:0] sleep_load;

    assign sleep_load = SLP_W'((32'(sleep_code) + 32'd1) * 32'(SLEEP_UNIT) - 32'd1);
    assign chk_bypass = (check_count == '0);

    rx_ovr_filter #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_ovr (
        .clk(clk), .rst_n(rst_n), .pin_n(force_rx_n),
        .force_on(force_on), .rel_pulse(rel_pulse)
    );

    // Remember whether the current sleep period is the parked variant.
    always_ff @(posedge clk) begin
        if (!rst_n || load_sleep) park_q <= (sleep_code == PARK_CODE);
    end

    rx_down_timer #(.W(SLP_W)) u_sleep_tmr (
        .clk(clk), .rst_n(rst_n), .load(load_sleep),
        .load_val(sleep_load), .hold(park_q), .done(sleep_done)
    );

    rx_down_timer #(.W(ST_W)) u_start_tmr (
        .clk(clk), .rst_n(rst_n), .load(load_start),
        .load_val(ST_W'(STARTUP_CYC - 1)), .hold(1'b0), .done(start_done)
    );

    rx_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .force_on(force_on), .rel_pulse(rel_pulse),
        .sleep_done(sleep_done), .start_done(start_done), .chk_bypass(chk_bypass),
        .chk_pass(chk_pass), .chk_fail(chk_fail), .state(state),
        .load_sleep(load_sleep), .load_start(load_start)
    );

    assign mode       = state;
    assign startup_en = (state == RXM_STARTUP);
    assign bitchk_en  = (state == RXM_BITCHK);

endmodule

// File: rtl/polling_mode_seq_chk.sv
// Module: polling_mode_seq_chk
// Temporal checks on the sequencer, attached through bind.
// Assumes: it is bound into polling_mode_seq and sees its internal strobes.
module polling_mode_seq_chk
    import rx_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       chk_pass,
    input logic       chk_fail,
    input logic       startup_en,
    input logic       bitchk_en,
    input logic       force_on,
    input logic       rel_pulse,
    input logic       park_q
);
    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == RXM_SLEEP |=> (mode == RXM_SLEEP || mode == RXM_STARTUP)); // R2
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RXM_SLEEP && park_q && !force_on) |=> mode == RXM_SLEEP); // R3
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(startup_en && bitchk_en)); // R4
    AST_STARTUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == RXM_STARTUP |=> mode != RXM_SLEEP); // R4
    AST_PASS_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RXM_BITCHK && chk_pass) |=> mode == RXM_RECEIVE); // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RXM_RECEIVE && !rel_pulse) |=> mode == RXM_RECEIVE); // R6
    AST_FAIL_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RXM_BITCHK && chk_fail && !chk_pass && !force_on) |=> mode == RXM_SLEEP); // R7
    AST_FORCED_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RXM_BITCHK && force_on) |=> mode == RXM_RECEIVE); // R9
endmodule

bind polling_mode_seq polling_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .chk_pass(chk_pass),
    .chk_fail(chk_fail), .startup_en(startup_en), .bitchk_en(bitchk_en),
    .force_on(force_on), .rel_pulse(rel_pulse), .park_q(park_q)
);

// File: tb/polling_mode_seq_test.sv
`timescale 1ns/1ps
module polling_mode_seq_test;
    localparam int UNIT = 4;
    localparam int SCYC = 6;
    localparam int OND  = 4;
    localparam int OFFD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_rx_n = 1'b1;
    logic [4:0] sleep_code = 5'd2;
    logic [3:0] check_count = 4'd1;
    logic       chk_pass = 1'b0;
    logic       chk_fail = 1'b0;
    logic [1:0] mode;
    logic       startup_en;
    logic       bitchk_en;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    polling_mode_seq #(
        .CODE_W(5), .CNT_W(4), .SLEEP_UNIT(UNIT), .STARTUP_CYC(SCYC),
        .ON_DLY(OND), .OFF_DLY(OFFD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .force_rx_n(force_rx_n), .sleep_code(sleep_code),
        .check_count(check_count), .chk_pass(chk_pass), .chk_fail(chk_fail),
        .mode(mode), .startup_en(startup_en), .bitchk_en(bitchk_en)
    );

    function automatic int exp_sleep(input int code);
        return (code + 1) * UNIT;
    endfunction
    function automatic int exp_on();
        return OND + 3;
    endfunction
    function automatic int exp_off();
        return OFFD + 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // Count consecutive falling-edge samples in mode m; flag enable mismatches.
    task automatic count_in(input logic [1:0] m, output int n, output int en_bad);
        n = 0; en_bad = 0;
        while (mode == m && n < 5000) begin
            if (startup_en != (mode == 2'd1) || bitchk_en != (mode == 2'd2)) en_bad++;
            n++;
            @(negedge clk);
        end
    endtask

    // Count rising edges until mode equals m.
    task automatic edges_to(input logic [1:0] m, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (mode != m && n < 5000);
    endtask

    // From receiving: pulse override low, release, check the polling return.
    task automatic leave_rx();
        int n, eb;
        check_count = 4'd1;
        force_rx_n = 1'b0;
        repeat (10) @(negedge clk);
        check(mode == 2'd3, "R6 receive held", mode, 3);
        force_rx_n = 1'b1;
        edges_to(2'd0, n);
        check(n == exp_off(), "R10 release latency", n, exp_off());
        count_in(2'd0, n, eb);
        check(n == exp_sleep(sleep_code), "R10 sleep after release", n, exp_sleep(sleep_code));
        count_in(2'd1, n, eb);
        check(n == SCYC && eb == 0, "R4 startup length", n, SCYC);
        check(mode == 2'd2 && bitchk_en, "R4 bit check follows", mode, 2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int n, eb, c, k, outcome, bad;
        void'($urandom(32'h1F2E3D));
        repeat (4) @(negedge clk);
        check(mode == 2'd0 && !startup_en && !bitchk_en, "R1 reset state", mode, 0);
        rst_n = 1'b1;
        check(mode == 2'd0 && !startup_en && !bitchk_en, "R1 first cycle", mode, 0);
        count_in(2'd0, n, eb);
        check(n == exp_sleep(2) && eb == 0, "R2 sleep after reset", n, exp_sleep(2));
        count_in(2'd1, n, eb);
        check(n == SCYC && eb == 0, "R4 startup length", n, SCYC);
        check(mode == 2'd2 && bitchk_en && !startup_en, "R4 bit check", mode, 2);

        for (int it = 0; it < 16; it++) begin
            c = int'($urandom % 8);
            k = int'($urandom % 3);
            outcome = int'($urandom % 2);
            if (outcome == 0) begin
                sleep_code = 5'(c); check_count = 4'(k); chk_fail = 1'b1;
                @(negedge clk); chk_fail = 1'b0;
                check(mode == 2'd0, "R7 fail to sleep", mode, 0);
                count_in(2'd0, n, eb);
                check(n == exp_sleep(c), "R7 R2 sleep period", n, exp_sleep(c));
                count_in(2'd1, n, eb);
                check(n == SCYC && eb == 0, "R4 startup length", n, SCYC);
                if (k == 0) begin
                    check(mode == 2'd3, "R5 bypass to receive", mode, 3);
                    leave_rx();
                end else begin
                    check(mode == 2'd2, "R4 bit check follows", mode, 2);
                end
            end else begin
                sleep_code = 5'(c); chk_pass = 1'b1;
                @(negedge clk); chk_pass = 1'b0;
                check(mode == 2'd3, "R6 pass to receive", mode, 3);
                leave_rx();
            end
        end

        // R3: park code holds sleep
        sleep_code = 5'd31; chk_fail = 1'b1;
        @(negedge clk); chk_fail = 1'b0;
        bad = 0;
        repeat (300) begin
            if (mode != 2'd0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R3 parked sleep", bad, 0);

        // R11: short override glitch ignored
        force_rx_n = 1'b0;
        repeat (OND - 1) @(negedge clk);
        force_rx_n = 1'b1;
        bad = 0;
        repeat (20) begin
            if (mode != 2'd0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R11 glitch ignored", bad, 0);

        // R8/R9/R10: forced wake from parked sleep, inputs ignored, release
        check_count = 4'd2;
        force_rx_n = 1'b0;
        edges_to(2'd1, n);
        check(n == exp_on(), "R8 wake latency", n, exp_on());
        sleep_code = 5'd5;
        count_in(2'd1, n, eb);
        check(n == SCYC && eb == 0, "R8 forced startup length", n, SCYC);
        check(mode == 2'd3, "R9 forced receive despite count", mode, 3);
        force_rx_n = 1'b1;
        edges_to(2'd0, n);
        check(n == exp_off(), "R10 release latency", n, exp_off());
        count_in(2'd0, n, eb);
        check(n == exp_sleep(5), "R10 programmed sleep kept", n, exp_sleep(5));
        count_in(2'd1, n, eb);
        check(mode == 2'd2, "R4 bit check after startup", mode, 2);

        // R9: override during bit check
        force_rx_n = 1'b0;
        edges_to(2'd3, n);
        check(n == exp_on(), "R9 bit check override latency", n, exp_on());
        force_rx_n = 1'b1;
        edges_to(2'd0, n);
        check(n == exp_off(), "R10 release latency", n, exp_off());

        finish_run();
    end
endmodule